// File: doc/BRIEF.md
# I/O Window Address Decoder

This block sits on a 10-bit I/O address bus and turns accesses to a 32-address window into 32 active-low device enables, at most one low at a time. A bus access counts only when a read or write strobe is low and the address-enable line is low. When that line is high, the cycle belongs to a DMA transfer and every enable stays high. The window base is a parameter aligned to 32, and the default base is 0x300.

The upper address bits 9:5 are compared with the base. Bit 4 picks one of two 16-output bank decoders, and bits 3:0 pick the output inside that bank. Enables 0 to 3 are merged into one active-low chip select for a parallel-port peripheral, which reads its register offset from address bits 1:0. The enables and the offset are registered, so the outputs change only at a clock edge and carry no decode glitches. The design uses an asynchronous active-low reset whose release is synchronised inside the block.

Top module: `iodec_top`

## Requirements
- R1: While reset is asserted, every `dev_en_n` bit is 1, `port_cs_n` is 1 and `port_reg_sel` is 0.
- R2: When `io_addr[9:5]` equals `BASE[9:5]`, `aen` is 0 and a strobe is low at a rising edge, exactly bit `io_addr[4:0]` of `dev_en_n` is 0 after that edge. Address bit 4 = 0 selects enables 0–15 and bit 4 = 1 selects enables 16–31.
- R3: An access sampled with `aen` = 1 leaves all `dev_en_n` bits at 1, even inside the window.
- R4: A read-only access (`io_rd_n`=0, `io_wr_n`=1), a write-only access and an access with both strobes low all decode identically.
- R5: An address with `io_addr[9:5]` different from `BASE[9:5]` leaves all `dev_en_n` bits at 1.
- R6: No more than one `dev_en_n` bit is 0 at any time.
- R7: `port_cs_n` is 0 exactly when one of `dev_en_n[3:0]` is 0, that is, for decoded addresses BASE+0 to BASE+3.
- R8: `port_reg_sel` holds `io_addr[1:0]` of the most recent decoded access, and it keeps its value across accesses that do not decode.
- R9: With both strobes high, all `dev_en_n` bits are 1 whatever the address and `aen` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 10 | I/O address bus |
| io_rd_n | input | 1 | Read strobe, active low |
| io_wr_n | input | 1 | Write strobe, active low |
| aen | input | 1 | Address enable, high during DMA cycles |
| dev_en_n | output | 32 | One-hot active-low device enables, index = address offset in window |
| port_cs_n | output | 1 | Active-low chip select for offsets 0–3 |
| port_reg_sel | output | 2 | Register offset of the last decoded access |

## Verification
Every enable, `port_cs_n` and `port_reg_sel` is due at the first rising edge after the inputs are set up, because each comes from one register stage. The bench drives the inputs on a falling edge and samples on the next falling edge. At that point exactly one capturing edge has passed, and the inputs were stable across it. After reset is released, the synchroniser needs two edges, so the bench waits several cycles before the first vector. Every address from 0 to 1023 is checked with the access kind varied. Random vectors then mix DMA cycles, idle strobes and in-window addresses.

// File: rtl/iodec_pkg.sv
package iodec_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_BOTH  = 2'b11
  } iodec_acc_e;

  function automatic iodec_acc_e acc_kind(input logic rd_n, input logic wr_n);
    return iodec_acc_e'({~wr_n, ~rd_n});
  endfunction

endpackage

// File: rtl/iodec_rst_sync.sv
module iodec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic stage_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      sync_q  <= stage_q;
    end
  end

  assign rst_s_n = sync_q;

endmodule

// File: rtl/iodec_window_match.sv
module iodec_window_match #(
  parameter int                ADDR_W = 10,
  parameter int                WIN_W  = 5,
  parameter logic [ADDR_W-1:0] BASE   = 10'h300
) (
  input  logic [ADDR_W-1:WIN_W] addr_hi,
  input  logic                  aen,
  input  logic                  req,
  output logic                  win_n
);

  localparam int                 TAG_W = ADDR_W - WIN_W;
  localparam logic [TAG_W-1:0]   TAG   = BASE[ADDR_W-1:WIN_W];

  logic tag_eq;

  always_comb begin
    tag_eq = (addr_hi == TAG);
    win_n  = !(tag_eq && !aen && req);
  end

endmodule

// File: rtl/iodec_bank_decoder.sv
module iodec_bank_decoder #(
  parameter int SEL_W = 4
) (
  input  logic                    en_n,
  input  logic [SEL_W-1:0]        sel,
  output logic [(1<<SEL_W)-1:0]   out_n
);

  localparam int N_OUT = 1 << SEL_W;

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    assign out_n[g] = en_n | (sel != SEL_W'(g));
  end

endmodule

// File: rtl/iodec_port_select.sv
module iodec_port_select #(
  parameter int GRP = 4
) (
  input  logic [GRP-1:0] grp_en_n,
  output logic           cs_n
);

  always_comb cs_n = &grp_en_n;

endmodule

// File: rtl/iodec_top.sv
module iodec_top #(
  parameter int          ADDR_W = 10,
  parameter int          BANK_W = 4,
  parameter int          WIN_W  = 5,
  parameter int          OFF_W  = 2,
  parameter logic [9:0]  BASE   = 10'h300
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic                   io_rd_n,
  input  logic                   io_wr_n,
  input  logic                   aen,
  output logic [(1<<WIN_W)-1:0]  dev_en_n,
  output logic                   port_cs_n,
  output logic [OFF_W-1:0]       port_reg_sel
);
  import iodec_pkg::*;

  localparam int N_EN      = 1 << WIN_W;
  localparam int BSEL_W    = WIN_W - BANK_W;
  localparam int N_BANKS   = 1 << BSEL_W;
  localparam int BANK_OUTS = 1 << BANK_W;
  localparam int GRP       = 1 << OFF_W;

  logic               rst_s_n;
  logic               req;
  logic               win_n;
  logic [N_BANKS-1:0] bank_en_n;
  logic [N_EN-1:0]    dev_en_d;
  logic [N_EN-1:0]    dev_en_q;
  logic               off_ld;
  logic [OFF_W-1:0]   reg_sel_d;
  logic [OFF_W-1:0]   reg_sel_q;

  iodec_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  always_comb req = (acc_kind(io_rd_n, io_wr_n) != ACC_IDLE);

  iodec_window_match #(
    .ADDR_W (ADDR_W),
    .WIN_W  (WIN_W),
    .BASE   (BASE)
  ) u_match (
    .addr_hi (io_addr[ADDR_W-1:WIN_W]),
    .aen     (aen),
    .req     (req),
    .win_n   (win_n)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign bank_en_n[b] = win_n | (io_addr[WIN_W-1:BANK_W] != BSEL_W'(b));

    iodec_bank_decoder #(
      .SEL_W (BANK_W)
    ) u_bank (
      .en_n  (bank_en_n[b]),
      .sel   (io_addr[BANK_W-1:0]),
      .out_n (dev_en_d[b*BANK_OUTS +: BANK_OUTS])
    );
  end

  always_comb begin
    off_ld    = !win_n;
    reg_sel_d = io_addr[OFF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dev_en_q <= '1;
    end else begin
      dev_en_q <= dev_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      reg_sel_q <= '0;
    end else if (off_ld) begin
      reg_sel_q <= reg_sel_d;
    end
  end

  iodec_port_select #(
    .GRP (GRP)
  ) u_port (
    .grp_en_n (dev_en_q[GRP-1:0]),
    .cs_n     (port_cs_n)
  );

  assign dev_en_n     = dev_en_q;
  assign port_reg_sel = reg_sel_q;

  logic hit_chk;
  always_comb hit_chk = (io_addr[ADDR_W-1:WIN_W] == BASE[ADDR_W-1:WIN_W]) &&
                        !aen && !(io_rd_n && io_wr_n);

  assert_decode_hit_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    hit_chk |=> !dev_en_n[$past(io_addr[WIN_W-1:0])]);

  assert_dma_quiet_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    aen |=> (&dev_en_n));

  assert_outside_quiet_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (io_addr[ADDR_W-1:WIN_W] != BASE[ADDR_W-1:WIN_W]) |=> (&dev_en_n));

  assert_one_enable_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(~dev_en_n));

  assert_port_group_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hit_chk && io_addr[WIN_W-1:OFF_W] == '0) |=> !port_cs_n);

  assert_offset_load_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    hit_chk |=> (port_reg_sel == $past(io_addr[OFF_W-1:0])));

  assert_offset_hold_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !hit_chk |=> $stable(port_reg_sel));

  assert_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (io_rd_n && io_wr_n) |=> (&dev_en_n));

endmodule

// File: tb/iodec_top_tb_top.sv
module iodec_top_tb_top;

  localparam int         CLK_PERIOD = 10;
  localparam logic [9:0] BASE_T     = 10'h300;
  localparam int         WDOG_LIM   = 100000;

  logic        clk;
  logic        rst_n;
  logic [9:0]  io_addr;
  logic        io_rd_n;
  logic        io_wr_n;
  logic        aen;
  logic [31:0] dev_en_n;
  logic        port_cs_n;
  logic [1:0]  port_reg_sel;

  int n_vec;
  int n_bad;
  bit done;
  logic [1:0] exp_sel;

  iodec_top dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_addr      (io_addr),
    .io_rd_n      (io_rd_n),
    .io_wr_n      (io_wr_n),
    .aen          (aen),
    .dev_en_n     (dev_en_n),
    .port_cs_n    (port_cs_n),
    .port_reg_sel (port_reg_sel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit model_hit(logic [9:0] a, logic rd_n, logic wr_n, logic en);
    return (a[9:5] == BASE_T[9:5]) && !en && !(rd_n && wr_n);
  endfunction

  function automatic logic [31:0] model_en(logic [9:0] a, logic rd_n, logic wr_n, logic en);
    logic [31:0] r;
    r = '1;
    if (model_hit(a, rd_n, wr_n, en)) r[a[4:0]] = 1'b0;
    return r;
  endfunction

  task automatic check_vec(string req, logic [31:0] e_en, logic e_cs, logic [1:0] e_sel);
    n_vec++;
    if (dev_en_n !== e_en) begin
      n_bad++;
      $display("FAIL %s addr=%h dev_en_n actual=%h expected=%h", req, io_addr, dev_en_n, e_en);
    end
    if (port_cs_n !== e_cs) begin
      n_bad++;
      $display("FAIL R7 addr=%h port_cs_n actual=%b expected=%b", io_addr, port_cs_n, e_cs);
    end
    if (port_reg_sel !== e_sel) begin
      n_bad++;
      $display("FAIL R8 addr=%h port_reg_sel actual=%0d expected=%0d", io_addr, port_reg_sel, e_sel);
    end
    if ($countones(~dev_en_n) > 1) begin
      n_bad++;
      $display("FAIL R6 dev_en_n actual=%h expected at most one low", dev_en_n);
    end
  endtask

  task automatic apply(logic [9:0] a, logic rd_n, logic wr_n, logic en, string req_in);
    logic [31:0] e_en;
    bit          h;
    string       req;
    @(negedge clk);
    io_addr = a; io_rd_n = rd_n; io_wr_n = wr_n; aen = en;
    h    = model_hit(a, rd_n, wr_n, en);
    e_en = model_en(a, rd_n, wr_n, en);
    if (h) exp_sel = a[1:0];
    if (req_in != "") req = req_in;
    else if (rd_n && wr_n) req = "R9";
    else if (en) req = "R3";
    else if (!h) req = "R5";
    else req = "R2";
    @(negedge clk);
    check_vec(req, e_en, !(h && a[4:2] == 3'd0), exp_sel);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    for (int c = 0; c < WDOG_LIM; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin : stim
    logic [9:0] a;
    logic       rd, wr, en;
    n_vec = 0; n_bad = 0; done = 1'b0; exp_sel = 2'd0;
    void'($urandom(32'h1DEC0DE));
    rst_n = 1'b0; io_addr = BASE_T; io_rd_n = 1'b0; io_wr_n = 1'b1; aen = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_vec("R1", '1, 1'b1, 2'd0);
    rst_n = 1'b1;
    io_rd_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2/R5: full address sweep, alternating read and write strobes (R4)
    for (int i = 0; i < 1024; i++) begin
      apply(10'(i), i[0], !i[0], 1'b0, "");
    end

    // R4: each access kind at one address gives the same enable
    apply(BASE_T + 10'd21, 1'b0, 1'b1, 1'b0, "R4");
    apply(BASE_T + 10'd21, 1'b1, 1'b0, 1'b0, "R4");
    apply(BASE_T + 10'd21, 1'b0, 1'b0, 1'b0, "R4");

    // R2 bank boundary: bit 4 picks the upper bank
    apply(BASE_T + 10'd15, 1'b0, 1'b1, 1'b0, "R2");
    apply(BASE_T + 10'd16, 1'b0, 1'b1, 1'b0, "R2");
    apply(BASE_T + 10'd31, 1'b1, 1'b0, 1'b0, "R2");

    // R8: offset loads, then holds across DMA, idle and out-of-window cycles
    apply(BASE_T + 10'd2, 1'b1, 1'b0, 1'b0, "R8");
    apply(BASE_T + 10'd1, 1'b0, 1'b1, 1'b1, "R3");
    apply(BASE_T + 10'd3, 1'b1, 1'b1, 1'b0, "R9");
    apply(10'h2FF, 1'b0, 1'b1, 1'b0, "R5");
    apply(10'h320, 1'b0, 1'b1, 1'b0, "R5");
    apply(BASE_T + 10'd7, 1'b0, 1'b1, 1'b0, "R8");

    // R3: DMA over every window address
    for (int i = 0; i < 32; i++) begin
      apply(BASE_T + 10'(i), 1'b0, 1'b0, 1'b1, "R3");
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      a  = ($urandom % 2 == 0) ? (BASE_T | 10'($urandom % 32)) : 10'($urandom);
      rd = 1'($urandom);
      wr = 1'($urandom);
      en = ($urandom % 4 == 0);
      apply(a, rd, wr, en, "");
    end

    finish_run();
  end

endmodule